// File: doc/BRIEF.md
# Receive FIFO with Per-Byte Error Tags and Line-Status Interrupt

This block sits behind a UART deserializer. Each accepted byte goes into a receive FIFO along with three error tags (framing, parity, break), and the tags move through the FIFO with their byte. The block drives one interrupt line and a 3-bit identification code. Software, or a DMA engine, pops bytes from the head of the FIFO.

The moment a line-status error is reported depends on the mode. In interrupt mode a tagged byte raises the line-status condition only when it becomes the head of the FIFO. In DMA mode the condition is raised on the same clock edge that stores the tagged byte, even when clean bytes are queued ahead of it. The condition holds until every tagged byte has been popped. The identification code and the interrupt line are produced by one state register, so they change together on the same edge.

A three-state machine makes the identification code. Its states are NONE, DATA and LINE. Its transitions are raise-line (NONE to LINE), raise-data (NONE to DATA), promote (DATA to LINE), demote (LINE to DATA), clear-line (LINE to NONE) and clear-data (DATA to NONE). Each edge it loads the state that matches the FIFO contents being stored on that same edge.

Top module: `rx_err_fifo`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the FIFO, clears the overrun flag and the reported error flags, drops `irq`, and sets `iir` to 3'b001.
- R2: Bytes leave in arrival order. `head_byte` shows the oldest stored byte while `head_valid` is 1, and a `fifo_pop` at a clock edge moves to the next byte.
- R3: With `dma_mode` low, a tagged byte raises the line-status code (`iir` = 3'b110) from the edge on which it becomes the head of the FIFO. `lsr_err` then shows its tags as {break, parity, framing} in bits [2:0].
- R4: With `dma_mode` high, a tagged byte raises the line-status code from the edge that stores it, whatever is ahead of it. `lsr_err` shows the tags of the oldest tagged byte still stored.
- R5: In DMA mode the line-status code stays while any tagged byte is stored. It drops on the edge that pops the last one, unless an overrun is pending.
- R6: `irq` is 1 exactly when `iir[0]` is 0. `iir[0]` is an active-low pending bit, and 1 means nothing is pending.
- R7: `lsr_read` does not clear a line-status condition caused by a stored tagged byte.
- R8: When line status and data-available are both pending, `iir` shows 3'b110.
- R9: With `dma_mode` low, a non-empty FIFO with no line status gives `iir` = 3'b100. With `dma_mode` high, data alone never raises `irq`.
- R10: A byte that arrives while all DEPTH entries are full is discarded. It sets `lsr_ovr` and the line-status code on the next edge. `lsr_read` clears the overrun flag on the next edge.
- R11: `fifo_pop` while the FIFO is empty has no effect. A byte written in that same cycle is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_vld | input | 1 | Received-byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_frm | input | 1 | Framing error on this byte |
| rx_par | input | 1 | Parity error on this byte |
| rx_brk | input | 1 | Break detected on this byte |
| dma_mode | input | 1 | 1 selects DMA reporting, 0 selects interrupt reporting |
| fifo_pop | input | 1 | Remove the head byte |
| lsr_read | input | 1 | Line-status register read strobe |
| head_byte | output | 8 | Byte at the head of the FIFO |
| head_valid | output | 1 | FIFO holds at least one byte |
| irq | output | 1 | Interrupt request |
| iir | output | 3 | Identification: bit 0 active-low pending, bits [2:1] source (11 line, 10 data) |
| lsr_err | output | 3 | Reported tags {break, parity, framing} |
| lsr_ovr | output | 1 | Overrun flag |

## Verification
The bench puts clean bytes ahead of a tagged one and runs the same sequence in both modes. A design that used the head-of-FIFO rule in DMA mode, or the arrival rule in interrupt mode, would raise the interrupt at the wrong edge. It also checks, on every vector, that the pending bit and the interrupt line agree. A design that pulsed the interrupt before the code changed, or cleared the condition on a register read, would break that agreement or drop the line too early. It fills all 64 entries and sends one more byte, then drains the FIFO. A FIFO that wrapped over its oldest entry, failed to flag the overrun, or stored the extra byte would show a wrong head byte or a missing overrun. A pop on an empty FIFO made together with a write shows whether the design corrupts its count in that case.

// File: rtl/rxef_pkg.sv
package rxef_pkg;

    typedef struct packed {
        logic brk;
        logic par;
        logic frm;
    } rx_tag_t;

    typedef enum logic [1:0] {
        ST_NONE,
        ST_DATA,
        ST_LINE
    } irq_state_e;

    localparam logic [2:0] IIR_NONE = 3'b001;
    localparam logic [2:0] IIR_DATA = 3'b100;
    localparam logic [2:0] IIR_LINE = 3'b110;

endpackage

// File: rtl/rxef_store.sv
module rxef_store
    import rxef_pkg::*;
#(
    parameter int DEPTH = 64,   // power of two
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_vld,
    input  logic [DW-1:0] wr_data,
    input  rx_tag_t       wr_tag,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    output rx_tag_t       head_tag,
    output rx_tag_t       head_tag_nxt,
    output rx_tag_t       oldest_tag,
    output logic          empty,
    output logic          ovf_hit,
    output logic          nonempty_nxt,
    output logic          tag_live,
    output logic          tag_live_nxt
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] dmem [DEPTH];
    rx_tag_t       tmem [DEPTH];
    logic [AW-1:0] rd_q, wr_q, rd_d;
    logic [CW-1:0] cnt_q, cnt_d, tcnt_q, tcnt_d, remain;
    logic          full, wr_acc, pop_acc, wr_tagged, pop_tagged, found;

    assign full       = (cnt_q == CW'(DEPTH));
    assign empty      = (cnt_q == '0);
    assign wr_acc     = wr_vld && !full;
    assign pop_acc    = pop && !empty;
    assign ovf_hit    = wr_vld && full;
    assign head_tag   = tmem[rd_q];
    assign rd_data    = dmem[rd_q];
    assign wr_tagged  = wr_acc && (wr_tag != '0);
    assign pop_tagged = pop_acc && (head_tag != '0);

    assign cnt_d  = cnt_q + CW'(wr_acc) - CW'(pop_acc);
    assign tcnt_d = tcnt_q + CW'(wr_tagged) - CW'(pop_tagged);
    assign rd_d   = rd_q + AW'(pop_acc);
    assign remain = cnt_q - CW'(pop_acc);

    assign nonempty_nxt = (cnt_d != '0);
    assign tag_live     = (tcnt_q != '0);
    assign tag_live_nxt = (tcnt_d != '0);

    // Tags of the head entry as it will be after this edge
    always_comb begin
        if (remain == '0)
            head_tag_nxt = wr_acc ? wr_tag : '0;
        else
            head_tag_nxt = tmem[rd_d];
    end

    // Oldest stored entry that carries any tag
    always_comb begin
        oldest_tag = '0;
        found      = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && (CW'(i) < cnt_q) && (tmem[rd_q + AW'(i)] != '0)) begin
                oldest_tag = tmem[rd_q + AW'(i)];
                found      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_acc) begin
            dmem[wr_q] <= wr_data;
            tmem[wr_q] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= '0;
            wr_q   <= '0;
            cnt_q  <= '0;
            tcnt_q <= '0;
        end else begin
            rd_q   <= rd_d;
            wr_q   <= wr_q + AW'(wr_acc);
            cnt_q  <= cnt_d;
            tcnt_q <= tcnt_d;
        end
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    p_pop_empty_r11: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !wr_vld) |=> (cnt_q == '0));

    p_tag_bound_r5: assert property (@(posedge clk) disable iff (rst)
        tcnt_q <= cnt_q);

endmodule

// File: rtl/rxef_irq_fsm.sv
module rxef_irq_fsm
    import rxef_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_nxt,
    input  logic       data_nxt,
    output logic       irq,
    output logic [2:0] iir
);

    irq_state_e state_q, state_d;

    // Line status outranks data-available
    always_comb begin
        unique case (state_q)
            ST_NONE: state_d = line_nxt ? ST_LINE : (data_nxt ? ST_DATA : ST_NONE);
            ST_DATA: state_d = line_nxt ? ST_LINE : (data_nxt ? ST_DATA : ST_NONE);
            ST_LINE: state_d = line_nxt ? ST_LINE : (data_nxt ? ST_DATA : ST_NONE);
            default: state_d = ST_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_NONE;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_LINE: begin irq = 1'b1; iir = IIR_LINE; end
            ST_DATA: begin irq = 1'b1; iir = IIR_DATA; end
            ST_NONE: begin irq = 1'b0; iir = IIR_NONE; end
            default: begin irq = 1'b0; iir = IIR_NONE; end
        endcase
    end

    p_line_prio_r8: assert property (@(posedge clk) disable iff (rst)
        line_nxt |=> (iir == IIR_LINE));

    p_data_code_r9: assert property (@(posedge clk) disable iff (rst)
        (data_nxt && !line_nxt) |=> (iir == IIR_DATA));

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
    import rxef_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_vld,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_frm,
    input  logic          rx_par,
    input  logic          rx_brk,
    input  logic          dma_mode,
    input  logic          fifo_pop,
    input  logic          lsr_read,
    output logic [DW-1:0] head_byte,
    output logic          head_valid,
    output logic          irq,
    output logic [2:0]    iir,
    output logic [2:0]    lsr_err,
    output logic          lsr_ovr
);

    rx_tag_t in_tag, head_tag, head_tag_nxt, oldest_tag, shown_tag;
    logic    empty, ovf_hit, nonempty_nxt, tag_live, tag_live_nxt;
    logic    dma_q, ovr_q, ovr_d, line_nxt, data_nxt;

    assign in_tag = '{brk: rx_brk, par: rx_par, frm: rx_frm};

    rxef_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk          (clk),
        .rst          (rst),
        .wr_vld       (rx_vld),
        .wr_data      (rx_byte),
        .wr_tag       (in_tag),
        .pop          (fifo_pop),
        .rd_data      (head_byte),
        .head_tag     (head_tag),
        .head_tag_nxt (head_tag_nxt),
        .oldest_tag   (oldest_tag),
        .empty        (empty),
        .ovf_hit      (ovf_hit),
        .nonempty_nxt (nonempty_nxt),
        .tag_live     (tag_live),
        .tag_live_nxt (tag_live_nxt)
    );

    // Overrun: a set on this edge wins over a clear by a read
    assign ovr_d = ovf_hit ? 1'b1 : (lsr_read ? 1'b0 : ovr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
            dma_q <= 1'b0;
        end else begin
            ovr_q <= ovr_d;
            dma_q <= dma_mode;
        end
    end

    // Conditions as they will stand after this edge
    assign line_nxt = ovr_d | (dma_mode ? tag_live_nxt : (head_tag_nxt != '0));
    assign data_nxt = !dma_mode && nonempty_nxt;

    rxef_irq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .line_nxt (line_nxt),
        .data_nxt (data_nxt),
        .irq      (irq),
        .iir      (iir)
    );

    assign head_valid = !empty;
    assign shown_tag  = dma_q ? oldest_tag : (empty ? '0 : head_tag);
    assign lsr_err    = shown_tag;
    assign lsr_ovr    = ovr_q;

    p_head_tag_r3: assert property (@(posedge clk) disable iff (rst)
        (!dma_q && head_valid && (head_tag != '0)) |-> (iir == IIR_LINE));

    p_dma_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (dma_q && tag_live) |-> (irq && iir == IIR_LINE));

    p_ovr_line_r10: assert property (@(posedge clk) disable iff (rst)
        ovr_q |-> (iir == IIR_LINE));

    p_pend_agree_r6: assert property (@(posedge clk) disable iff (rst)
        irq == !iir[0]);

endmodule

// File: tb/sim_rx_err_fifo.sv
module sim_rx_err_fifo;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_vld = 1'b0, rx_frm = 1'b0, rx_par = 1'b0, rx_brk = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       dma_mode = 1'b0, fifo_pop = 1'b0, lsr_read = 1'b0;
    logic [7:0] head_byte;
    logic       head_valid, irq, lsr_ovr;
    logic [2:0] iir, lsr_err;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rx_err_fifo u0 (
        .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .rx_frm(rx_frm), .rx_par(rx_par), .rx_brk(rx_brk),
        .dma_mode(dma_mode), .fifo_pop(fifo_pop), .lsr_read(lsr_read),
        .head_byte(head_byte), .head_valid(head_valid), .irq(irq),
        .iir(iir), .lsr_err(lsr_err), .lsr_ovr(lsr_ovr)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the rising edge
    task automatic step(input logic dm, input logic v, input logic [7:0] d,
                        input logic [2:0] t, input logic p, input logic lr);
        @(negedge clk);
        dma_mode = dm; rx_vld = v; rx_byte = d;
        {rx_brk, rx_par, rx_frm} = t;
        fifo_pop = p; lsr_read = lr;
        @(posedge clk);
        #1;
    endtask

    // req | dma vld data tag pop lrd | irq iir err nonempty head
    localparam int NV = 18;
    localparam logic [34:0] TBL [NV] = '{
        {4'd9,  1'b0,1'b1,8'hA1,3'b000,1'b0,1'b0, 1'b1,3'b100,3'b000,1'b1,8'hA1}, // R9 data code
        {4'd3,  1'b0,1'b1,8'hB2,3'b001,1'b0,1'b0, 1'b1,3'b100,3'b000,1'b1,8'hA1}, // R3 not at head yet
        {4'd7,  1'b0,1'b0,8'h00,3'b000,1'b0,1'b1, 1'b1,3'b100,3'b000,1'b1,8'hA1}, // R7
        {4'd8,  1'b0,1'b0,8'h00,3'b000,1'b1,1'b0, 1'b1,3'b110,3'b001,1'b1,8'hB2}, // R8 line over data
        {4'd7,  1'b0,1'b0,8'h00,3'b000,1'b0,1'b1, 1'b1,3'b110,3'b001,1'b1,8'hB2}, // R7 read keeps it
        {4'd3,  1'b0,1'b0,8'h00,3'b000,1'b1,1'b0, 1'b0,3'b001,3'b000,1'b0,8'h00}, // R3 cleared by pop
        {4'd9,  1'b1,1'b1,8'hC3,3'b000,1'b0,1'b0, 1'b0,3'b001,3'b000,1'b1,8'hC3}, // R9 no data irq in DMA
        {4'd4,  1'b1,1'b1,8'hD4,3'b010,1'b0,1'b0, 1'b1,3'b110,3'b010,1'b1,8'hC3}, // R4 behind clean byte
        {4'd4,  1'b1,1'b1,8'hE5,3'b100,1'b0,1'b0, 1'b1,3'b110,3'b010,1'b1,8'hC3}, // R4 oldest shown
        {4'd7,  1'b1,1'b0,8'h00,3'b000,1'b0,1'b1, 1'b1,3'b110,3'b010,1'b1,8'hC3}, // R7
        {4'd5,  1'b1,1'b0,8'h00,3'b000,1'b1,1'b0, 1'b1,3'b110,3'b010,1'b1,8'hD4}, // R5
        {4'd5,  1'b1,1'b0,8'h00,3'b000,1'b1,1'b0, 1'b1,3'b110,3'b100,1'b1,8'hE5}, // R5 one left
        {4'd5,  1'b1,1'b0,8'h00,3'b000,1'b1,1'b0, 1'b0,3'b001,3'b000,1'b0,8'h00}, // R5 last popped
        {4'd11, 1'b1,1'b1,8'hF6,3'b001,1'b1,1'b0, 1'b1,3'b110,3'b001,1'b1,8'hF6}, // R11 pop on empty + write
        {4'd5,  1'b1,1'b0,8'h00,3'b000,1'b1,1'b0, 1'b0,3'b001,3'b000,1'b0,8'h00}, // R5
        {4'd3,  1'b0,1'b1,8'h17,3'b011,1'b0,1'b0, 1'b1,3'b110,3'b011,1'b1,8'h17}, // R3 straight to head
        {4'd2,  1'b0,1'b0,8'h00,3'b000,1'b1,1'b0, 1'b0,3'b001,3'b000,1'b0,8'h00}, // R2
        {4'd11, 1'b0,1'b0,8'h00,3'b000,1'b1,1'b0, 1'b0,3'b001,3'b000,1'b0,8'h00}  // R11 pop on empty
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 irq", irq, 0);
        chk("R1 iir", iir, 3'b001);
        chk("R1 head_valid", head_valid, 0);
        chk("R1 lsr_ovr", lsr_ovr, 0);
        chk("R1 lsr_err", lsr_err, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            logic [34:0] v;
            string r;
            v = TBL[k];
            step(v[30], v[29], v[28:21], v[20:18], v[17], v[16]);
            r = $sformatf("R%0d vec%0d", v[34:31], k);
            chk({r, " irq"}, irq, v[15]);
            chk({r, " iir"}, iir, v[14:12]);
            chk({r, " lsr_err"}, lsr_err, v[11:9]);
            chk({r, " head_valid"}, head_valid, v[8]);
            if (v[8]) chk({r, " head_byte"}, head_byte, v[7:0]);
            chk($sformatf("R6 vec%0d pending bit", k), irq, !iir[0]);
        end

        // R10: fill all 64 entries, then one more
        for (int i = 0; i < 64; i++) step(1'b0, 1'b1, 8'(i + 8'h40), 3'b000, 1'b0, 1'b0);
        chk("R9 full no line", iir, 3'b100);
        chk("R10 no ovr yet", lsr_ovr, 0);
        step(1'b0, 1'b1, 8'hEE, 3'b111, 1'b0, 1'b0);
        chk("R10 ovr set", lsr_ovr, 1);
        chk("R10 line code", iir, 3'b110);
        chk("R10 irq", irq, 1);
        chk("R10 discarded tags not shown", lsr_err, 0);
        step(1'b0, 1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
        chk("R10 ovr cleared", lsr_ovr, 0);
        chk("R10 back to data", iir, 3'b100);
        // R2: drain in order; the discarded byte never appears
        for (int i = 0; i < 64; i++) begin
            chk("R2 order", head_byte, 8'(i + 8'h40));
            step(1'b0, 1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
        end
        chk("R2 drained", head_valid, 0);
        chk("R2 idle code", iir, 3'b001);

        // R1: reset with a pending DMA error
        step(1'b1, 1'b1, 8'h5A, 3'b001, 1'b0, 1'b0);
        chk("R4 pre-reset line", iir, 3'b110);
        @(negedge clk);
        rx_vld = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 mid irq", irq, 0);
        chk("R1 mid iir", iir, 3'b001);
        chk("R1 mid empty", head_valid, 0);
        chk("R1 mid lsr_err", lsr_err, 0);
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 1'b0, 8'h00, 3'b000, 1'b0, 1'b0);
        chk("R1 stays idle", iir, 3'b001);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

endmodule